// File: doc/BRIEF.md
# Configurable Serial Transceiver with Stick Parity

This block is a full-duplex asynchronous serial transceiver. A programmable divisor on the system clock produces a baud tick at sixteen times the bit rate. A transmit engine and a receive engine both count that tick. Runtime inputs set the character length (5 to 8 bits), one or two stop bits, and whether a parity bit is present. They also set odd or even parity and a stick mode, in which the parity bit is a fixed constant and not computed from the data.

Software or a neighbouring block writes bytes through a valid/ready handshake into a single holding register. Frames go out with no idle gap between them while that register stays fed. The receiver synchronises the line and accepts a start bit only when it is still low at mid-bit. It then samples every following bit at its centre. Each received character appears for one cycle with a strobe, together with its parity and framing error flags. A programmable timeout reports a line that stays silent after the last character.

Top module: `uart_link`

## Requirements
- R1: The baud tick fires once every `cfg_divisor` clocks, and a value of 0 or 1 gives a tick on every clock. Every transmitted bit lasts exactly 16 ticks.
- R2: The line idles high. A frame begins with one low start bit, followed by data bits sent least significant bit first. The count of data bits is 5, 6, 7 or 8 for `cfg_char_len` codes 00, 01, 10 and 11.
- R3: When `cfg_two_stop` is 0 the frame ends with one high stop bit, and when it is 1 with two. Back-to-back frames start exactly 16 × divisor × (1 + data bits + parity bit + stop bits) clocks apart.
- R4: With `cfg_parity_en` set, one parity bit follows the data. It makes the count of ones odd when `cfg_parity_even` is 0 and even when it is 1. Data bits beyond the character length are not counted.
- R5: With both `cfg_parity_en` and `cfg_parity_stick` set, the parity bit is 1 when `cfg_parity_even` is 0 and 0 when it is 1, whatever the data.
- R6: `tx_ready` is high while the holding register is empty. A byte is taken on a clock where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low on the next cycle.
- R7: The receiver confirms a start bit 8 ticks after the falling edge. A low pulse shorter than that produces no character. Each character is presented on `rx_data` with a one-cycle `rx_valid`, and bits above the character length read 0.
- R8: `rx_parity_err` is 1 with `rx_valid` when the received parity bit differs from the value R4 or R5 gives. It changes only on cycles where `rx_valid` is high.
- R9: `rx_frame_err` is 1 with `rx_valid` when any stop-bit sample reads low, including the second stop bit when two are selected.
- R10: After a character is received, if no new start bit begins within `cfg_rx_timeout` ticks, `rx_timeout` pulses high for exactly one cycle. A value of 0 disables the pulse.
- R11: During and after reset, `tx_line` is high, `tx_ready` is high, and `rx_valid` and `rx_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_divisor | input | DIV_W | System clocks per oversampling tick |
| cfg_char_len | input | 2 | Character length code (00=5 … 11=8 bits) |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_parity_en | input | 1 | Insert and check a parity bit |
| cfg_parity_even | input | 1 | 0: odd parity, 1: even parity |
| cfg_parity_stick | input | 1 | Force the parity bit to a constant |
| cfg_rx_timeout | input | TMO_W | Idle ticks before the timeout pulse, 0 disables it |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Holding register is empty |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle strobe for a new character |
| rx_parity_err | output | 1 | Parity mismatch on the reported character |
| rx_frame_err | output | 1 | A stop bit was sampled low |
| rx_timeout | output | 1 | One-cycle pulse when the line stays idle too long |

## Verification
The bench goes after frame timing at the edges. Back-to-back spacing at divisors 0, 1 and 3 shows whether a transmitter adds an idle tick between frames or miscounts a stop bit. Stick parity is checked with data of both parities, so a design that still computes the bit fails on half the bytes. Errors are injected in the second stop bit and in the parity bit. A glitch shorter than half a bit is also injected, and a receiver without mid-bit confirmation would report a phantom character. The timeout pulse is measured against its tick window and checked for a single occurrence.

// File: rtl/uart_link_pkg.sv
package uart_link_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    // Parity bit for a character of (5 + len) bits, honouring stick mode.
    function automatic logic parity_of(input logic [7:0] d,
                                       input logic [1:0] len,
                                       input logic       even,
                                       input logic       stick);
        logic [7:0] m;
        m = d & (8'hFF >> (2'd3 - len));
        if (stick) return ~even;
        return even ? ^m : ~^m;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } bg_t;

    bg_t b_d, b_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        b_d = b_q;
        lim = (cfg_div <= DIV_W'(1)) ? '0 : cfg_div - DIV_W'(1);
        if (b_q.cnt >= lim) begin
            b_d.cnt  = '0;
            b_d.tick = 1'b1;
        end else begin
            b_d.cnt  = b_q.cnt + DIV_W'(1);
            b_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign tick = b_q.tick;

    // R1: with a divisor above one, ticks never come on adjacent clocks
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg_div > DIV_W'(1)) |=> !tick);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_two_stop,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_par_stick,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       tx_line
);
    typedef struct packed {
        logic       hold_full;
        logic [7:0] hold_data;
        phase_e     phase;
        logic [7:0] shreg;
        logic [2:0] bit_idx;
        logic [3:0] sub;
        logic       stop_idx;
        logic       line;
        logic [1:0] len;
        logic       two_stop;
        logic       par_en;
        logic       par_val;
    } tx_t;

    tx_t t_d, t_q;
    logic bit_end;
    logic load;

    always_comb begin
        t_d     = t_q;
        bit_end = tick && (t_q.sub == 4'd15);
        load    = 1'b0;

        if (tx_valid && !t_q.hold_full) begin
            t_d.hold_full = 1'b1;
            t_d.hold_data = tx_data;
        end

        if (tick && t_q.phase != PH_IDLE) t_d.sub = t_q.sub + 4'd1;

        unique case (t_q.phase)
            PH_IDLE: begin
                t_d.line = 1'b1;
                if (tick && t_q.hold_full) load = 1'b1;
            end
            PH_START: begin
                if (bit_end) begin
                    t_d.phase   = PH_DATA;
                    t_d.bit_idx = 3'd0;
                    t_d.line    = t_q.shreg[0];
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    if (t_q.bit_idx == (3'(t_q.len) + 3'd4)) begin
                        if (t_q.par_en) begin
                            t_d.phase = PH_PAR;
                            t_d.line  = t_q.par_val;
                        end else begin
                            t_d.phase    = PH_STOP;
                            t_d.stop_idx = 1'b0;
                            t_d.line     = 1'b1;
                        end
                    end else begin
                        t_d.bit_idx = t_q.bit_idx + 3'd1;
                        t_d.shreg   = t_q.shreg >> 1;
                        t_d.line    = t_q.shreg[1];
                    end
                end
            end
            PH_PAR: begin
                if (bit_end) begin
                    t_d.phase    = PH_STOP;
                    t_d.stop_idx = 1'b0;
                    t_d.line     = 1'b1;
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    if (t_q.two_stop && !t_q.stop_idx) t_d.stop_idx = 1'b1;
                    else if (t_q.hold_full)            load = 1'b1;
                    else                               t_d.phase = PH_IDLE;
                end
            end
            default: t_d.phase = PH_IDLE;
        endcase

        if (load) begin
            t_d.hold_full = 1'b0;
            t_d.phase     = PH_START;
            t_d.sub       = 4'd0;
            t_d.line      = 1'b0;
            t_d.shreg     = t_q.hold_data;
            t_d.len       = cfg_len;
            t_d.two_stop  = cfg_two_stop;
            t_d.par_en    = cfg_par_en;
            t_d.par_val   = parity_of(t_q.hold_data, cfg_len, cfg_par_even, cfg_par_stick);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q       <= '0;
            t_q.phase <= PH_IDLE;
            t_q.line  <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end

    assign tx_ready = !t_q.hold_full;
    assign tx_line  = t_q.line;

    // R6: an accepted byte fills the holding register for at least one cycle
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
    // R2: the line is high whenever no frame is in progress
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_IDLE) |-> tx_line);
    // R3: stop bits are driven high
    a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.phase == PH_STOP) |-> tx_line);

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_link_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx_line,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_two_stop,
    input  logic             cfg_par_en,
    input  logic             cfg_par_even,
    input  logic             cfg_par_stick,
    input  logic [TMO_W-1:0] cfg_timeout,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_parity_err,
    output logic             rx_frame_err,
    output logic             rx_timeout
);
    localparam logic [TMO_W:0] ONE_T = (TMO_W+1)'(1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             prev;
        phase_e           phase;
        logic [3:0]       sub;
        logic [2:0]       bit_idx;
        logic [7:0]       data;
        logic             par_bad;
        logic             frm_bad;
        logic             stop_idx;
        logic [7:0]       out_data;
        logic             valid;
        logic             perr;
        logic             ferr;
        logic             tmo_arm;
        logic [TMO_W-1:0] tmo_cnt;
        logic             tmo_hit;
    } rx_t;

    rx_t r_d, r_q;
    logic line_s, fall, mid, last_bit, stop_bad;

    assign line_s = r_q.sync[1];

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.tmo_hit = 1'b0;
        r_d.sync    = {r_q.sync[0], rx_line};
        r_d.prev    = line_s;
        fall        = r_q.prev && !line_s;
        mid         = tick && (r_q.sub == 4'd15);
        last_bit    = (r_q.bit_idx == (3'(cfg_len) + 3'd4));
        stop_bad    = r_q.frm_bad | ~line_s;

        if (tick && r_q.phase != PH_IDLE) r_d.sub = r_q.sub + 4'd1;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (fall) begin
                    r_d.phase   = PH_START;
                    r_d.sub     = 4'd0;
                    r_d.tmo_arm = 1'b0;
                    r_d.tmo_cnt = '0;
                end else if (tick && r_q.tmo_arm && cfg_timeout != '0) begin
                    if (({1'b0, r_q.tmo_cnt} + ONE_T) >= {1'b0, cfg_timeout}) begin
                        r_d.tmo_hit = 1'b1;
                        r_d.tmo_arm = 1'b0;
                    end else begin
                        r_d.tmo_cnt = r_q.tmo_cnt + TMO_W'(1);
                    end
                end
            end
            PH_START: begin
                if (tick && r_q.sub == 4'd7) begin
                    if (!line_s) begin
                        r_d.phase   = PH_DATA;
                        r_d.sub     = 4'd0;
                        r_d.bit_idx = 3'd0;
                        r_d.data    = 8'h00;
                        r_d.par_bad = 1'b0;
                        r_d.frm_bad = 1'b0;
                    end else begin
                        r_d.phase = PH_IDLE;
                    end
                end
            end
            PH_DATA: begin
                if (mid) begin
                    r_d.data[r_q.bit_idx] = line_s;
                    if (last_bit) begin
                        if (cfg_par_en) begin
                            r_d.phase = PH_PAR;
                        end else begin
                            r_d.phase    = PH_STOP;
                            r_d.stop_idx = 1'b0;
                        end
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + 3'd1;
                    end
                end
            end
            PH_PAR: begin
                if (mid) begin
                    r_d.par_bad  = line_s != parity_of(r_q.data, cfg_len, cfg_par_even, cfg_par_stick);
                    r_d.phase    = PH_STOP;
                    r_d.stop_idx = 1'b0;
                end
            end
            PH_STOP: begin
                if (mid) begin
                    if (cfg_two_stop && !r_q.stop_idx) begin
                        r_d.stop_idx = 1'b1;
                        r_d.frm_bad  = stop_bad;
                    end else begin
                        r_d.phase    = PH_IDLE;
                        r_d.valid    = 1'b1;
                        r_d.out_data = r_q.data;
                        r_d.perr     = r_q.par_bad;
                        r_d.ferr     = stop_bad;
                        r_d.tmo_arm  = 1'b1;
                        r_d.tmo_cnt  = '0;
                    end
                end
            end
            default: r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
            r_q.sync  <= 2'b11;
            r_q.prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data       = r_q.out_data;
    assign rx_valid      = r_q.valid;
    assign rx_parity_err = r_q.perr;
    assign rx_frame_err  = r_q.ferr;
    assign rx_timeout    = r_q.tmo_hit;

    // R7: a character strobe lasts one cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: error flags move only together with a new character
    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_parity_err) && $stable(rx_frame_err)));
    // R10: the timeout pulse lasts one cycle
    a_r10_tmo_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> !rx_timeout);
    // R10: the timeout never coincides with a character strobe
    a_r10_tmo_apart: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> !rx_valid);

endmodule

// File: rtl/uart_link.sv
module uart_link #(
    parameter int DIV_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_divisor,
    input  logic [1:0]       cfg_char_len,
    input  logic             cfg_two_stop,
    input  logic             cfg_parity_en,
    input  logic             cfg_parity_even,
    input  logic             cfg_parity_stick,
    input  logic [TMO_W-1:0] cfg_rx_timeout,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_line,
    input  logic             rx_line,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_parity_err,
    output logic             rx_frame_err,
    output logic             rx_timeout
);
    logic tick;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_div (cfg_divisor),
        .tick    (tick)
    );

    uart_tx_engine u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .cfg_len       (cfg_char_len),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_par_en    (cfg_parity_en),
        .cfg_par_even  (cfg_parity_even),
        .cfg_par_stick (cfg_parity_stick),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_line       (tx_line)
    );

    uart_rx_engine #(.TMO_W(TMO_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .rx_line       (rx_line),
        .cfg_len       (cfg_char_len),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_par_en    (cfg_parity_en),
        .cfg_par_even  (cfg_parity_even),
        .cfg_par_stick (cfg_parity_stick),
        .cfg_timeout   (cfg_rx_timeout),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .rx_parity_err (rx_parity_err),
        .rx_frame_err  (rx_frame_err),
        .rx_timeout    (rx_timeout)
    );

endmodule

// File: tb/sim_uart_link.sv
`timescale 1ns/1ps
module sim_uart_link;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [15:0] cfg_divisor;
    logic [1:0]  cfg_char_len;
    logic        cfg_two_stop, cfg_parity_en, cfg_parity_even, cfg_parity_stick;
    logic [15:0] cfg_rx_timeout;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready, tx_line;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_parity_err, rx_frame_err, rx_timeout;
    logic        loop_en = 1'b1;
    logic        drv_line = 1'b1;
    wire         rx_line = loop_en ? tx_line : drv_line;

    uart_link u0 (
        .clk(clk), .rst_n(rst_n), .cfg_divisor(cfg_divisor), .cfg_char_len(cfg_char_len),
        .cfg_two_stop(cfg_two_stop), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_even(cfg_parity_even), .cfg_parity_stick(cfg_parity_stick),
        .cfg_rx_timeout(cfg_rx_timeout), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_line(tx_line), .rx_line(rx_line), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_timeout(rx_timeout)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_div();
        return (cfg_divisor <= 16'd1) ? 1 : int'(cfg_divisor);
    endfunction

    function automatic logic [7:0] mask8(input logic [7:0] d, input logic [1:0] len);
        logic [7:0] m = 8'h00;
        for (int i = 0; i < 5 + int'(len); i++) m[i] = d[i];
        return m;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] len,
                                     input logic even, input logic stick);
        int ones = 0;
        if (stick) return !even;
        for (int i = 0; i < 5 + int'(len); i++) ones += int'(d[i]);
        return even ? logic'(ones % 2 == 1) : logic'(ones % 2 == 0);
    endfunction

    function automatic int frame_bits();
        return 1 + 5 + int'(cfg_char_len) + int'(cfg_parity_en) + 1 + int'(cfg_two_stop);
    endfunction

    // receive monitor
    logic [7:0] rx_log_d [0:255];
    bit         rx_log_p [0:255];
    bit         rx_log_f [0:255];
    int         rx_log_c [0:255];
    int         rx_n = 0;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_log_d[rx_n & 255] = rx_data;
            rx_log_p[rx_n & 255] = rx_parity_err;
            rx_log_f[rx_n & 255] = rx_frame_err;
            rx_log_c[rx_n & 255] = cyc;
            rx_n = rx_n + 1;
        end
    end

    int tmo_n = 0, tmo_c = 0;
    always @(negedge clk) begin
        if (rst_n && rx_timeout) begin
            tmo_n = tmo_n + 1;
            tmo_c = cyc;
        end
    end

    // transmit line decoder
    logic [7:0] dec_d    [0:255];
    bit         dec_p    [0:255];
    bit         dec_ok   [0:255];
    int         dec_edge [0:255];
    int         dec_n = 0;
    logic       prev_tx = 1'b1;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && prev_tx && !tx_line) begin
                automatic int d = eff_div();
                automatic logic [7:0] v = 8'h00;
                automatic bit ok = 1'b1;
                automatic bit p = 1'b0;
                dec_edge[dec_n & 255] = cyc;
                repeat (8 * d) @(negedge clk);
                if (tx_line) ok = 1'b0;
                for (int i = 0; i < 5 + int'(cfg_char_len); i++) begin
                    repeat (16 * d) @(negedge clk);
                    v[i] = tx_line;
                end
                if (cfg_parity_en) begin
                    repeat (16 * d) @(negedge clk);
                    p = tx_line;
                end
                for (int s = 0; s < 1 + int'(cfg_two_stop); s++) begin
                    repeat (16 * d) @(negedge clk);
                    if (!tx_line) ok = 1'b0;
                end
                dec_d[dec_n & 255]  = v;
                dec_p[dec_n & 255]  = p;
                dec_ok[dec_n & 255] = ok;
                dec_n = dec_n + 1;
            end
            prev_tx = tx_line;
        end
    end

    task automatic tx_send(input logic [7:0] b, input bit check_ready);
        while (!tx_ready) @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        if (check_ready) chk(!tx_ready, "R6", "ready low after accept", int'(tx_ready), 0);
    endtask

    task automatic do_frame(input logic [7:0] b);
        int r0 = rx_n;
        int d0 = dec_n;
        logic [7:0] m = mask8(b, cfg_char_len);
        tx_send(b, 1'b1);
        for (int k = 0; k < 30000 && !(rx_n > r0 && dec_n > d0); k++) @(negedge clk);
        repeat (16 * eff_div() + 8) @(negedge clk);
        chk(rx_n == r0 + 1, "R7", "one char received", rx_n - r0, 1);
        chk(dec_d[d0 & 255] == m, "R2", "line data bits", int'(dec_d[d0 & 255]), int'(m));
        chk(dec_ok[d0 & 255], "R3", "start low and stop bits high", int'(dec_ok[d0 & 255]), 1);
        if (cfg_parity_en)
            chk(dec_p[d0 & 255] == exp_par(b, cfg_char_len, cfg_parity_even, cfg_parity_stick),
                cfg_parity_stick ? "R5" : "R4", "line parity bit", int'(dec_p[d0 & 255]),
                int'(exp_par(b, cfg_char_len, cfg_parity_even, cfg_parity_stick)));
        chk(rx_log_d[r0 & 255] == m, "R7", "rx_data", int'(rx_log_d[r0 & 255]), int'(m));
        chk(!rx_log_p[r0 & 255], "R8", "no parity error", int'(rx_log_p[r0 & 255]), 0);
        chk(!rx_log_f[r0 & 255], "R9", "no framing error", int'(rx_log_f[r0 & 255]), 0);
    endtask

    task automatic b2b(input logic [7:0] a, input logic [7:0] b, input string req);
        int r0 = rx_n;
        int d0 = dec_n;
        int expg;
        tx_send(a, 1'b0);
        tx_send(b, 1'b0);
        for (int k = 0; k < 30000 && !(rx_n >= r0 + 2 && dec_n >= d0 + 2); k++) @(negedge clk);
        repeat (16 * eff_div() + 8) @(negedge clk);
        expg = 16 * eff_div() * frame_bits();
        chk(dec_edge[(d0 + 1) & 255] - dec_edge[d0 & 255] == expg, req, "frame spacing",
            dec_edge[(d0 + 1) & 255] - dec_edge[d0 & 255], expg);
        chk(rx_log_d[(r0 + 1) & 255] == mask8(b, cfg_char_len), "R6", "second back-to-back byte",
            int'(rx_log_d[(r0 + 1) & 255]), int'(mask8(b, cfg_char_len)));
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic pv, input logic s1, input logic s2);
        int bt = 16 * eff_div();
        drv_line = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < 5 + int'(cfg_char_len); i++) begin
            drv_line = b[i];
            repeat (bt) @(negedge clk);
        end
        if (cfg_parity_en) begin
            drv_line = pv;
            repeat (bt) @(negedge clk);
        end
        drv_line = s1;
        repeat (bt) @(negedge clk);
        if (cfg_two_stop) begin
            drv_line = s2;
            repeat (bt) @(negedge clk);
        end
        drv_line = 1'b1;
        repeat (bt) @(negedge clk);
    endtask

    task automatic inject(input logic [7:0] b, input logic pv, input logic s1, input logic s2,
                          input bit ep, input bit ef, input string req);
        int r0 = rx_n;
        drive_frame(b, pv, s1, s2);
        chk(rx_n == r0 + 1, req, "injected char count", rx_n - r0, 1);
        chk(rx_log_d[r0 & 255] == mask8(b, cfg_char_len), req, "injected data",
            int'(rx_log_d[r0 & 255]), int'(mask8(b, cfg_char_len)));
        chk(rx_log_p[r0 & 255] == ep, req, "parity flag", int'(rx_log_p[r0 & 255]), int'(ep));
        chk(rx_log_f[r0 & 255] == ef, req, "framing flag", int'(rx_log_f[r0 & 255]), int'(ef));
    endtask

    task automatic set_cfg(input int div, input logic [1:0] len, input logic two,
                           input logic pe, input logic ev, input logic st);
        cfg_divisor = 16'(div); cfg_char_len = len; cfg_two_stop = two;
        cfg_parity_en = pe; cfg_parity_even = ev; cfg_parity_stick = st;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int r0, t0, dl;
        rst_n = 1'b0; tx_valid = 1'b0; tx_data = 8'h00; cfg_rx_timeout = 16'd0;
        cfg_divisor = 16'd4; cfg_char_len = 2'd3; cfg_two_stop = 1'b0;
        cfg_parity_en = 1'b0; cfg_parity_even = 1'b0; cfg_parity_stick = 1'b0;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(tx_line === 1'b1, "R11", "tx_line in reset", int'(tx_line), 1);
        chk(tx_ready === 1'b1, "R11", "tx_ready in reset", int'(tx_ready), 1);
        chk(rx_valid === 1'b0, "R11", "rx_valid in reset", int'(rx_valid), 0);
        chk(rx_timeout === 1'b0, "R11", "rx_timeout in reset", int'(rx_timeout), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(tx_line === 1'b1, "R11", "tx_line idle after reset", int'(tx_line), 1);
        chk(tx_ready === 1'b1, "R11", "tx_ready after reset", int'(tx_ready), 1);

        // directed: every length, parity modes, both stop counts
        for (int len = 0; len < 4; len++) begin
            set_cfg(4, 2'(len), len[0], len[0], len[1], 1'b0);
            do_frame(8'hA5 ^ 8'(len * 37));
        end
        set_cfg(3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);   // R5 stick, select odd -> bit 1
        do_frame(8'h01);
        do_frame(8'h03);
        set_cfg(3, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1);   // R5 stick, select even -> bit 0
        do_frame(8'h3F);
        do_frame(8'h20);

        // constrained random frames
        for (int n = 0; n < 24; n++) begin
            set_cfg(2 + int'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2),
                    1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            do_frame(8'($urandom));
        end

        // R1 / R3: back-to-back spacing at several divisors
        set_cfg(3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        b2b(8'h3C, 8'hC3, "R3");
        set_cfg(1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        b2b(8'h15, 8'h0A, "R1");
        set_cfg(0, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
        b2b(8'h7F, 8'h40, "R1");

        // injected errors on the receive side
        loop_en = 1'b0;
        set_cfg(4, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
        inject(8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8");   // even parity of A5 is 0
        inject(8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        set_cfg(4, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
        inject(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R5");   // stick odd expects 1
        set_cfg(4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        inject(8'h96, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R9");
        set_cfg(4, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        inject(8'h69, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9");   // second stop low
        set_cfg(4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        inject(8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");   // upper bits read 0
        r0 = rx_n;
        drv_line = 1'b0;
        repeat (4 * eff_div()) @(negedge clk);
        drv_line = 1'b1;
        repeat (40 * eff_div()) @(negedge clk);
        chk(rx_n == r0, "R7", "short glitch ignored", rx_n - r0, 0);
        set_cfg(4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        inject(8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");

        // R10 timeout
        set_cfg(3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_rx_timeout = 16'd20;
        t0 = tmo_n; r0 = rx_n;
        drive_frame(8'h33, 1'b0, 1'b1, 1'b1);
        repeat (200) @(negedge clk);
        chk(tmo_n == t0 + 1, "R10", "one timeout pulse", tmo_n - t0, 1);
        dl = tmo_c - rx_log_c[r0 & 255];
        chk(dl >= 19 * 3 && dl <= 20 * 3 + 1, "R10", "timeout delay cycles", dl, 60);
        repeat (200) @(negedge clk);
        chk(tmo_n == t0 + 1, "R10", "no repeated pulse", tmo_n - t0, 1);
        cfg_rx_timeout = 16'd0;
        t0 = tmo_n;
        drive_frame(8'hCC, 1'b0, 1'b1, 1'b1);
        repeat (400) @(negedge clk);
        chk(tmo_n == t0, "R10", "timeout disabled at 0", tmo_n - t0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule